// File: doc/BRIEF.md
# Carry-Save Product Rounder with Injected Rounding Constant

This block turns the redundant (carry-save) form of an exact significand product into a correctly rounded significand. It sits after the partial-product reduction tree of a floating-point multiplier. The operands are normalized significands in [1,2), so their exact product lies in [1,4). By the time the two strings reach this block, the reduction tree has already added a small constant into them, chosen by the rounding mode. Because that constant is already present, every supported mode reduces to a plain truncation plus a small increment decision. Round-to-nearest-even is formed as round-half-up followed by clearing the result LSB on an exact tie. Two tie detectors run side by side: one assumes the product stays below 2, the other assumes it reaches 2 or more.

The caller maps the sign and the IEEE direction onto three modes: truncate, nearest-even, and away-from-zero. The block returns the 53-bit rounded significand with its leading one, and a flag telling the exponent stage to add one. The flag is set when the product is 2 or more, or when rounding carried the value up to 2. The datapath is combinational, with an optional output register stage that captures only on a valid strobe.

Top module: `injrnd_rounder`

## Requirements
- R1: With mode code 2'b00 (truncate), `result` equals the exact product truncated to 53 significant bits, counted from the leading one.
- R2: With mode code 2'b01 (nearest-even), `result` is the exact product rounded to the nearest 53-bit value. On an exact tie the candidate with LSB (`result[0]`) equal to 0 is chosen, both for products below 2 and for products of 2 or more.
- R3: With mode code 2'b10 (away from zero), `result` is incremented at its LSB whenever any discarded bit of the exact product is nonzero, and equals the truncation when all discarded bits are zero.
- R4: `ovf` is 1 when the exact product is at least 2, or when rounding carried the value to exactly 2 (then `result` is 1.000…0). When `ovf` is 1, `result` holds the significand shifted right by one position.
- R5: The output depends only on the arithmetic value of `sum_i + carry_i`, not on how that value is split between the two strings.
- R6: Mode code 2'b11 behaves exactly like 2'b00, and the caller supplies no injection for it.
- R7: With the output register enabled (default), `out_valid`, `result` and `ovf` appear one clock after `in_valid` was sampled high, and `out_valid` is 0 one clock after `in_valid` was sampled low.
- R8: A clock edge with `in_valid` low leaves `result` and `ovf` unchanged, whatever values are on `sum_i`, `carry_i` and `rmode`.
- R9: While `rst_n` is low, `out_valid`, `result` and `ovf` are all 0.
- R10: Every valid result has its leading bit `result[52]` (weight 1) set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| in_valid | input | 1 | Strobe: the inputs hold a product to round |
| rmode | input | 2 | 00 truncate, 01 nearest-even, 10 away from zero, 11 same as 00 |
| sum_i | input | 106 | Sum string. Bit k has weight 2^(k-104), so bit 105 has weight 2 and bit 104 has weight 1. It already contains the injection: 0 for truncate, 2^-53 for nearest, 2^-52 - 2^-104 for away |
| carry_i | input | 106 | Carry string, same weighting as `sum_i` |
| out_valid | output | 1 | `result` and `ovf` hold a rounded product |
| result | output | 53 | Rounded significand. Bit 52 has weight 1 and bit 0 is the LSB |
| ovf | output | 1 | Normalization flag: the exponent must be incremented |

## Verification
The tie cases are where this design is most likely to go wrong. The bench builds exact half-way products whose kept LSB is odd and whose kept LSB is even, both below 2 and above 2. A rounder that swaps the two tie detectors, or that tests the wrong round-bit polarity after injection, keeps an odd LSB or clears an even one. Products whose kept bits are all ones are rounded away from zero. A design that takes the flag from the unincremented sum then reports no overflow while the value has become 2. Exact products in the away mode catch a spurious increment, and the same value fed as three different carry-save splits catches any dependence on the carry pattern. The hold and spare-mode checks catch a register that captures without the strobe and a decoder that treats code 11 as a rounding mode.

// File: rtl/injrnd_pkg.sv
package injrnd_pkg;

    typedef enum logic [1:0] {
        RM_TRUNC = 2'b00,
        RM_NEAR  = 2'b01,
        RM_AWAY  = 2'b10,
        RM_SPARE = 2'b11
    } rmode_e;

endpackage

// File: rtl/injrnd_lowpart.sv
module injrnd_lowpart #(
    parameter int unsigned FRAC_W = 52
) (
    input  logic [FRAC_W-1:0] sum_lo,
    input  logic [FRAC_W-1:0] car_lo,
    output logic              c_out,
    output logic              rbit,
    output logic              sticky
);
    logic [FRAC_W:0] lo_add;

    always_comb begin
        lo_add = {1'b0, sum_lo} + {1'b0, car_lo};
        c_out  = lo_add[FRAC_W];
        rbit   = lo_add[FRAC_W-1];
        sticky = |lo_add[FRAC_W-2:0];
    end
endmodule

// File: rtl/injrnd_halfline.sv
module injrnd_halfline #(
    parameter int unsigned FRAC_W = 52,
    localparam int unsigned HI_W  = FRAC_W + 2
) (
    input  logic [HI_W-1:0] sum_hi,
    input  logic [HI_W-1:0] car_hi,
    output logic [FRAC_W:0] xs,
    output logic [FRAC_W:0] xc,
    output logic            lx,
    output logic            top_gen
);
    logic [HI_W-1:0] hs;
    logic [HI_W-1:0] hg;

    for (genvar i = 0; i < HI_W; i++) begin : g_ha
        assign hs[i] = sum_hi[i] ^ car_hi[i];
        assign hg[i] = sum_hi[i] & car_hi[i];
    end

    assign lx      = hs[0];
    assign xs      = hs[HI_W-1:1];
    assign xc      = hg[FRAC_W:0];
    assign top_gen = hg[HI_W-1];
endmodule

// File: rtl/injrnd_compound.sv
module injrnd_compound #(
    parameter int unsigned W = 53
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y0,
    output logic [W-1:0] y1
);
    always_comb begin
        y0 = a + b;
        y1 = y0 + W'(1);
    end
endmodule

// File: rtl/injrnd_decide.sv
module injrnd_decide
    import injrnd_pkg::*;
#(
    parameter int unsigned FRAC_W = 52
) (
    input  rmode_e          mode,
    input  logic [FRAC_W:0] y0,
    input  logic [FRAC_W:0] y1,
    input  logic            lx,
    input  logic            cb,
    input  logic            rb,
    input  logic            sb,
    output logic [FRAC_W:0] res,
    output logic            ovf,
    output logic            inc,
    output logic            keep_n,
    output logic            keep_o
);
    logic              is_near;
    logic              is_away;
    logic [FRAC_W-1:0] z0;
    logic [FRAC_W-1:0] z1;
    logic              lsb;

    always_comb begin
        unique case (mode)
            RM_NEAR: begin is_near = 1'b1; is_away = 1'b0; end
            RM_AWAY: begin is_near = 1'b0; is_away = 1'b1; end
            default: begin is_near = 1'b0; is_away = 1'b0; end
        endcase
    end

    always_comb begin
        if (!y0[FRAC_W] || !(is_near || is_away)) begin
            inc = lx & cb;
        end else if (is_away) begin
            inc = lx | cb;
        end else begin
            inc = (rb & lx) | (rb & cb) | (lx & cb);
        end
    end

    always_comb begin
        z0     = y0[FRAC_W] ? y0[FRAC_W:1] : y0[FRAC_W-1:0];
        z1     = y1[FRAC_W] ? y1[FRAC_W:1] : y1[FRAC_W-1:0];
        ovf    = inc ? y1[FRAC_W] : y0[FRAC_W];
        keep_n = rb | sb | !is_near;
        keep_o = !(lx ^ cb) | !rb | sb | !is_near;
        if (!ovf) begin
            lsb = (lx ^ cb) & keep_n;
        end else if (inc) begin
            lsb = y1[0] & keep_o;
        end else begin
            lsb = y0[0] & keep_o;
        end
        res = {(inc ? z1 : z0), lsb};
    end
endmodule

// File: rtl/injrnd_rounder.sv
module injrnd_rounder
    import injrnd_pkg::*;
#(
    parameter int unsigned FRAC_W  = 52,
    parameter bit          OUT_REG = 1'b1,
    localparam int unsigned SIG_W  = FRAC_W + 1,
    localparam int unsigned PROD_W = 2 * SIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        rmode,
    input  logic [PROD_W-1:0] sum_i,
    input  logic [PROD_W-1:0] carry_i,
    output logic              out_valid,
    output logic [FRAC_W:0]   result,
    output logic              ovf
);
    logic            cb, rb, sb;
    logic [FRAC_W:0] xs, xc, y0, y1;
    logic            lx, top_gen;
    logic [FRAC_W:0] res_c;
    logic            ovf_c, inc_c, keep_n, keep_o;

    injrnd_lowpart #(.FRAC_W(FRAC_W)) u_low (
        .sum_lo (sum_i[FRAC_W-1:0]),
        .car_lo (carry_i[FRAC_W-1:0]),
        .c_out  (cb),
        .rbit   (rb),
        .sticky (sb)
    );

    injrnd_halfline #(.FRAC_W(FRAC_W)) u_ha (
        .sum_hi  (sum_i[PROD_W-1:FRAC_W]),
        .car_hi  (carry_i[PROD_W-1:FRAC_W]),
        .xs      (xs),
        .xc      (xc),
        .lx      (lx),
        .top_gen (top_gen)
    );

    injrnd_compound #(.W(SIG_W)) u_add (
        .a  (xs),
        .b  (xc),
        .y0 (y0),
        .y1 (y1)
    );

    injrnd_decide #(.FRAC_W(FRAC_W)) u_dec (
        .mode   (rmode_e'(rmode)),
        .y0     (y0),
        .y1     (y1),
        .lx     (lx),
        .cb     (cb),
        .rb     (rb),
        .sb     (sb),
        .res    (res_c),
        .ovf    (ovf_c),
        .inc    (inc_c),
        .keep_n (keep_n),
        .keep_o (keep_o)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                result    <= '0;
                ovf       <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    result <= res_c;
                    ovf    <= ovf_c;
                end
            end
        end

        p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(result) && $stable(ovf)));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = res_c;
        assign ovf       = ovf_c;
    end

    // R5: a legal carry-save pair below 4 never generates beyond weight 2
    p_no_top_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !top_gen);
    // R2: an increment always has a set bit at the LSB position feeding it
    p_inc_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inc_c) |-> (lx || cb));
    // R2: LSB pull-down is confined to nearest-even
    p_pull_rne_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rmode != 2'b01) |-> (keep_n && keep_o));
    p_lead_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> res_c[FRAC_W]);
endmodule

// File: tb/injrnd_rounder_tb.sv
module injrnd_rounder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int F  = 52;
    localparam int SW = F + 1;
    localparam int PW = 2 * SW;
    localparam logic [PW-1:0] ONE = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    rmode = 2'b00;
    logic [PW-1:0] sum_i = '0;
    logic [PW-1:0] carry_i = '0;
    logic          out_valid;
    logic [F:0]    result;
    logic          ovf;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    injrnd_rounder #(.FRAC_W(F), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rmode(rmode),
        .sum_i(sum_i), .carry_i(carry_i),
        .out_valid(out_valid), .result(result), .ovf(ovf)
    );

    function automatic logic [PW-1:0] rand_wide();
        logic [127:0] r;
        r = {$urandom, $urandom, $urandom, $urandom};
        return r[PW-1:0];
    endfunction

    function automatic logic [F:0] rand_sig();
        logic [63:0] r;
        r = {$urandom, $urandom};
        return {1'b1, r[F-1:0]};
    endfunction

    // Reference: round the full product, returns {ovf, significand}
    function automatic logic [SW:0] ref_round(input logic [PW-1:0] p, input logic [1:0] m);
        logic [SW:0] kept;
        logic half, more, up, top;
        top = p[PW-1];
        if (top) begin
            kept = {1'b0, p[PW-1:F+1]};
            half = p[F];
            more = |p[F-1:0];
        end else begin
            kept = {1'b0, p[PW-2:F]};
            half = p[F-1];
            more = |p[F-2:0];
        end
        case (m)
            2'b01:   up = half & (more | kept[0]);
            2'b10:   up = half | more;
            default: up = 1'b0;
        endcase
        kept = kept + {{SW{1'b0}}, up};
        if (kept[SW]) begin
            kept = {2'b01, {F{1'b0}}};
            top  = 1'b1;
        end
        return {top, kept[F:0]};
    endfunction

    task automatic check_out(input string req, input logic [F:0] exp_r,
                             input logic exp_o, input logic exp_v);
        n_checks++;
        if (result !== exp_r || ovf !== exp_o || out_valid !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual res=%h ovf=%b vld=%b expected res=%h ovf=%b vld=%b",
                     req, result, ovf, out_valid, exp_r, exp_o, exp_v);
        end
    endtask

    // Entered and left at a falling edge; split 0: no carry string,
    // 1: random carry string, 2: carry-free bit partition.
    task automatic run_op(input string req, input logic [F:0] a, input logic [F:0] b,
                          input logic [1:0] m, input int split);
        logic [PW-1:0] p, inj, tot, c, r;
        logic [SW:0]   e;
        p = PW'(a) * PW'(b);
        case (m)
            2'b01:   inj = ONE << (F-1);
            2'b10:   inj = (ONE << F) - ONE;
            default: inj = '0;
        endcase
        tot = p + inj;
        r = rand_wide();
        case (split)
            0:       c = '0;
            1:       c = r & ((ONE << (PW-2)) - ONE);
            default: c = tot & r;
        endcase
        carry_i  = c;
        sum_i    = tot - c;
        rmode    = m;
        in_valid = 1'b1;
        @(negedge clk);
        e = ref_round(p, m);
        check_out(req, e[F:0], e[SW], 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R9 reset", '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R7 idle after reset", '0, 1'b0, 1'b0);
    endtask

    task automatic t_exact();
        logic [F:0] one_p, onehalf;
        one_p   = {1'b1, {F{1'b0}}};
        onehalf = {2'b11, {(F-1){1'b0}}};
        for (int m = 0; m < 3; m++) begin
            run_op("R3 R1 R10 exact one", one_p, one_p, 2'(m), 1);
            run_op("R3 R4 exact 2.25", onehalf, onehalf, 2'(m), 2);
        end
    endtask

    task automatic t_ties_low();
        for (int m = 0; m < 3; m++) begin
            run_op("R2 low tie odd", {1'b1, {(F-1){1'b0}}, 1'b1}, {2'b11, {(F-1){1'b0}}}, 2'(m), 1);
            run_op("R2 low tie even", {1'b1, {(F-2){1'b0}}, 2'b10}, {3'b101, {(F-2){1'b0}}}, 2'(m), 1);
        end
    endtask

    task automatic t_ties_high();
        for (int m = 0; m < 3; m++) begin
            run_op("R2 R4 high tie odd", {2'b11, {(F-1){1'b0}}}, {2'b11, {(F-3){1'b0}}, 2'b10}, 2'(m), 1);
            run_op("R2 R4 high tie even", {2'b11, {(F-1){1'b0}}}, {2'b11, {(F-4){1'b0}}, 3'b110}, 2'(m), 2);
        end
    endtask

    task automatic t_carry_to_two();
        logic [F:0]    a, b;
        logic [PW-1:0] q, p, two;
        int            hits;
        two  = ONE << (PW-1);
        hits = 0;
        for (int k = 0; k < 200 && hits < 6; k++) begin
            a = rand_sig();
            q = two / PW'(a);
            b = q[F:0];
            p = PW'(a) * PW'(b);
            if (q[PW-1:SW] == '0 && b[F] && p < two && (two - p) <= (ONE << F)) begin
                hits++;
                run_op("R4 R3 round up to two", a, b, 2'b10, 1);
                run_op("R4 R2 near two", a, b, 2'b01, 1);
            end
        end
    endtask

    task automatic t_split();
        logic [F:0] a, b;
        for (int k = 0; k < 20; k++) begin
            a = rand_sig();
            b = rand_sig();
            for (int s = 0; s < 3; s++) begin
                run_op("R5 split", a, b, 2'(k % 3), s);
            end
        end
    endtask

    task automatic t_spare_mode();
        for (int k = 0; k < 20; k++) begin
            run_op("R6 spare code", rand_sig(), rand_sig(), 2'b11, k % 3);
        end
    endtask

    task automatic t_hold();
        logic [F:0] r0;
        logic       o0;
        run_op("R8 setup", rand_sig(), rand_sig(), 2'b10, 1);
        r0 = result;
        o0 = ovf;
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            sum_i   = rand_wide();
            carry_i = rand_wide();
            rmode   = 2'(k);
            @(negedge clk);
            check_out("R8 R7 hold when idle", r0, o0, 1'b0);
        end
    endtask

    task automatic t_random();
        for (int k = 0; k < 2400; k++) begin
            run_op("R1 R2 R3 random", rand_sig(), rand_sig(), 2'(k % 3), k % 3);
        end
    endtask

    initial begin
        t_reset();
        t_exact();
        t_ties_low();
        t_ties_high();
        t_carry_to_two();
        t_split();
        t_spare_mode();
        t_hold();
        t_random();
        in_valid = 1'b0;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule